// File: doc/BRIEF.md
# Converter Serial Command Port

This block is the digital serial front end of a sigma-delta converter. A host reaches it over a three-wire SPI-style link made of a chip select, a serial clock and a data input. A single output line carries both read data and a "result ready" indication. Every exchange opens with an 8-bit command byte. That byte names a register, a direction and an input channel. Exactly one register transfer follows the command, and the port then goes back to waiting for the next command.

On the core side, the port holds the mode and filter configuration bytes and the selected channel, and drives them out. It accepts each new 24-bit conversion word with a one-cycle strobe. Whenever the channel value changes, it raises a one-cycle restart pulse towards the filter.

A sticky streaming mode sends every new result out as soon as serial clocks arrive, with no command byte in front. While streaming, the port keeps watching the data input for the command that ends the mode. A run of 32 serial clocks with the data input high returns the whole port to its reset state, whatever state it is in.

All serial pins are synchronised into the system clock domain. Edges of the serial clock are detected there.

Top module: `adc_cmd_port`

## Requirements
- R1: After reset, and after every completed transfer, the port waits for a command byte, which it shifts in MSB first. While the data input reads 1 at the first command bit position, the port stays at that position. The first 0 seen there starts the command, and the next seven bits load it.
- R2: Command bit layout, MSB first: bit 7 is the start bit (0), bit 6 must be 0, bits 5:4 are the register (00 status on read / none on write, 01 mode, 10 filter, 11 result), bit 3 is the direction (1 read, 0 write), bit 2 requests streaming, and bits 1:0 are the channel. A byte whose bit 6 is 1 is discarded entirely: no register changes, the channel does not change, and the port waits again.
- R3: A write command to mode or filter takes the next 8 bits, MSB first, and presents them on the matching output after the 8th bit. A write command addressed to 00 or 11 ends at the command byte.
- R4: A read returns the addressed value MSB first: mode or filter (8 bits), status (8 bits: bit 7 is the ready flag, bits 6:2 are zero, bits 1:0 are the current channel), or the last conversion word (24 bits, passed through unchanged in offset binary).
- R5: Outside a data shift, the output line shows the ready flag. The flag goes to 0 when a conversion strobe arrives and to 1 once a result read completes. If a new result arrives during a result read, the flag stays 0 after that read. The output enable is active exactly while chip select is low.
- R6: The data input is sampled on rising serial clock edges. Read data changes on falling edges, and the first bit appears on the first falling edge after the command byte.
- R7: The command 001111xx enters streaming mode. While the ready flag is 0, the next 24 serial clocks shift out the newest result and then set the flag to 1. While the flag is 1, serial clocks shift nothing and the output line stays high.
- R8: In streaming mode, if the first 8 data-input bits of a result frame are 001110xx, the port leaves streaming mode once that frame ends and then waits for commands.
- R9: 32 consecutive rising serial clock edges with the data input high reset every register to its default (mode 0x00, filter 0x04, channel 00, ready flag 1) and return the port to command wait. This works in any state, streaming included. A run of 31 ones does not reset the port.
- R10: Raising chip select in the middle of a byte abandons that byte, and the next transfer starts a fresh command. The count of consecutive ones is kept across the deselect. While deselected, mode, filter and channel do not change.
- R11: A change of the channel value produces a restart pulse exactly one clock long. Selecting the channel already in use produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock, idles high |
| din | input | 1 | Serial data from the host |
| dout | output | 1 | Serial data / ready flag to the host |
| dout_oe | output | 1 | Output enable for dout (high while selected) |
| conv_data | input | 24 | Conversion result, offset binary |
| conv_valid | input | 1 | One-cycle strobe for a new conversion result |
| mode_cfg | output | 8 | Mode configuration byte |
| filt_cfg | output | 8 | Filter configuration byte |
| chan_sel | output | 2 | Selected input channel |
| chan_restart | output | 1 | One-cycle filter restart pulse on a channel change |

## Verification
The hardest case to reach is the end of streaming mode. The exit command only counts when it shows up in the first eight data-input bits of a result frame, and a frame only starts after a result is ready. The bench first strobes in a result and then drives the exit byte on the data input while clocking out that same result. Next it loads a second result and issues an ordinary mode read. If the port were still streaming, that read would return result bits instead of the mode byte. A conversion strobe timed in the middle of a result read is used in the same way to reach the case where the ready flag has to stay low.

// File: rtl/adc_sif_pkg.sv
package adc_sif_pkg;
    localparam int CMD_W = 8;

    typedef enum logic [2:0] {
        S_WAIT_WEN,
        S_CMD,
        S_WR,
        S_RD,
        S_CREAD
    } sif_state_t;

    typedef enum logic [1:0] {
        RA_COMM = 2'b00,
        RA_MODE = 2'b01,
        RA_FILT = 2'b10,
        RA_DATA = 2'b11
    } reg_addr_t;
endpackage

// File: rtl/adc_sif_sync.sv
module adc_sif_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    input  logic [W-1:0] rst_val,
    output logic [W-1:0] d_out
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= rst_val;
        end else begin
            pipe[0] <= d_in;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign d_out = pipe[STAGES-1];
endmodule

// File: rtl/adc_sif_runlen.sv
module adc_sif_runlen #(
    parameter int RUN_LEN = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_stb,
    input  logic bit_val,
    output logic fire
);
    localparam int CW = $clog2(RUN_LEN + 1);
    logic [CW-1:0] cnt;

    assign fire = bit_stb && bit_val && (cnt == CW'(RUN_LEN - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               cnt <= '0;
        else if (bit_stb) begin
            if (fire || !bit_val) cnt <= '0;
            else                  cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/adc_cmd_port.sv
module adc_cmd_port
    import adc_sif_pkg::*;
#(
    parameter int DATA_W      = 24,
    parameter int RUN_LEN     = 32,
    parameter int SYNC_STAGES = 2,
    parameter logic [CMD_W-1:0] MODE_DEF = 8'h00,
    parameter logic [CMD_W-1:0] FILT_DEF = 8'h04
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              din,
    output logic              dout,
    output logic              dout_oe,
    input  logic [DATA_W-1:0] conv_data,
    input  logic              conv_valid,
    output logic [CMD_W-1:0]  mode_cfg,
    output logic [CMD_W-1:0]  filt_cfg,
    output logic [1:0]        chan_sel,
    output logic              chan_restart
);
    localparam int BCW = $clog2(DATA_W + 1);
    localparam int PADW = DATA_W - CMD_W;

    logic cs_s, sclk_s, din_s, sclk_q;
    logic cs_act, rise, fall, srst;

    adc_sif_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_in({cs_n, sclk, din}),
        .rst_val(3'b110), .d_out({cs_s, sclk_s, din_s})
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_q <= 1'b1;
        else        sclk_q <= sclk_s;
    end

    assign cs_act = !cs_s;
    assign rise   = cs_act && sclk_s && !sclk_q;
    assign fall   = cs_act && !sclk_s && sclk_q;

    adc_sif_runlen #(.RUN_LEN(RUN_LEN)) u_run (
        .clk(clk), .rst_n(rst_n), .bit_stb(rise), .bit_val(din_s), .fire(srst)
    );

    sif_state_t st, st_nx;
    logic [BCW-1:0]    bcnt, rd_len;
    logic [CMD_W-2:0]  cmd_sh;
    logic [DATA_W-1:0] shreg, data_reg;
    reg_addr_t         addr_q;
    logic dout_q, frame, exit_pend, rdy_n, pend;

    logic [CMD_W-2:0] cbits;
    logic [CMD_W-1:0] wbyte;
    logic cmd_ok, c_rd, c_cr, exit_hit, rd_last, frame_last, read_end, in_data_rd;
    reg_addr_t c_addr;
    logic [1:0] c_ch;

    assign cbits      = {cmd_sh[CMD_W-3:0], din_s};
    assign wbyte      = {cmd_sh, din_s};
    assign cmd_ok     = !cbits[6];
    assign c_addr     = reg_addr_t'(cbits[5:4]);
    assign c_rd       = cbits[3];
    assign c_cr       = cbits[2];
    assign c_ch       = cbits[1:0];
    assign exit_hit   = (wbyte[7:2] == 6'b001110);
    assign rd_last    = rise && (bcnt == rd_len - 1'b1);
    assign frame_last = rise && frame && (bcnt == BCW'(DATA_W - 1));
    assign in_data_rd = (st == S_RD && addr_q == RA_DATA) || (st == S_CREAD && frame);
    assign read_end   = (st == S_RD && addr_q == RA_DATA && rd_last) ||
                        (st == S_CREAD && frame_last);

    // next-state logic
    always_comb begin
        st_nx = st;
        if (srst) st_nx = S_WAIT_WEN;
        else if (!cs_act && st inside {S_CMD, S_WR, S_RD}) st_nx = S_WAIT_WEN;
        else begin
            unique case (st)
                S_WAIT_WEN: if (rise && !din_s) st_nx = S_CMD;
                S_CMD: if (rise && bcnt == BCW'(6)) begin
                    if (!cmd_ok)   st_nx = S_WAIT_WEN;
                    else if (c_rd) st_nx = (c_addr == RA_DATA && c_cr) ? S_CREAD : S_RD;
                    else           st_nx = (c_addr == RA_MODE || c_addr == RA_FILT) ? S_WR : S_WAIT_WEN;
                end
                S_WR:    if (rise && bcnt == BCW'(7)) st_nx = S_WAIT_WEN;
                S_RD:    if (rd_last) st_nx = S_WAIT_WEN;
                S_CREAD: if (frame_last && exit_pend) st_nx = S_WAIT_WEN;
                default: st_nx = S_WAIT_WEN;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_WAIT_WEN;
        else        st <= st_nx;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_cfg <= MODE_DEF;  filt_cfg <= FILT_DEF;
            chan_sel <= 2'b00;     chan_restart <= 1'b0;
            rdy_n <= 1'b1;  pend <= 1'b0;  data_reg <= '0;
            bcnt <= '0;  rd_len <= BCW'(CMD_W);  cmd_sh <= '0;
            shreg <= '0;  dout_q <= 1'b1;  frame <= 1'b0;
            exit_pend <= 1'b0;  addr_q <= RA_COMM;
        end else begin
            chan_restart <= 1'b0;
            if (srst) begin
                mode_cfg <= MODE_DEF;  filt_cfg <= FILT_DEF;
                chan_sel <= 2'b00;     chan_restart <= (chan_sel != 2'b00);
                rdy_n <= 1'b1;  pend <= 1'b0;  data_reg <= '0;
                bcnt <= '0;  frame <= 1'b0;  exit_pend <= 1'b0;
                dout_q <= 1'b1;  addr_q <= RA_COMM;
            end else begin
                if (!cs_act) begin
                    bcnt <= '0;  frame <= 1'b0;  pend <= 1'b0;
                end else begin
                    unique case (st)
                        S_WAIT_WEN: bcnt <= '0;
                        S_CMD: if (rise) begin
                            cmd_sh <= cbits;
                            bcnt   <= bcnt + 1'b1;
                            if (bcnt == BCW'(6)) begin
                                bcnt <= '0;
                                if (cmd_ok) begin
                                    chan_sel     <= c_ch;
                                    chan_restart <= (c_ch != chan_sel);
                                    addr_q       <= c_addr;
                                    rd_len       <= (c_addr == RA_DATA) ? BCW'(DATA_W) : BCW'(CMD_W);
                                    frame        <= 1'b0;
                                    exit_pend    <= 1'b0;
                                    unique case (c_addr)
                                        RA_COMM: shreg <= {rdy_n, 5'b00000, c_ch, {PADW{1'b0}}};
                                        RA_MODE: shreg <= {mode_cfg, {PADW{1'b0}}};
                                        RA_FILT: shreg <= {filt_cfg, {PADW{1'b0}}};
                                        RA_DATA: shreg <= data_reg;
                                        default: shreg <= data_reg;
                                    endcase
                                end
                            end
                        end
                        S_WR: if (rise) begin
                            cmd_sh <= cbits;
                            bcnt   <= bcnt + 1'b1;
                            if (bcnt == BCW'(7)) begin
                                bcnt <= '0;
                                if (addr_q == RA_MODE) mode_cfg <= wbyte;
                                else                   filt_cfg <= wbyte;
                            end
                        end
                        S_RD: begin
                            if (fall) begin
                                dout_q <= shreg[DATA_W-1];
                                shreg  <= shreg << 1;
                            end
                            if (rise) begin
                                bcnt <= bcnt + 1'b1;
                                if (rd_last) begin
                                    bcnt <= '0;
                                    if (addr_q == RA_DATA) begin
                                        rdy_n <= !pend;  pend <= 1'b0;
                                    end
                                end
                            end
                        end
                        S_CREAD: begin
                            if (!frame) begin
                                bcnt  <= '0;
                                shreg <= data_reg;
                                if (fall && !rdy_n) begin
                                    frame     <= 1'b1;
                                    exit_pend <= 1'b0;
                                    dout_q    <= data_reg[DATA_W-1];
                                    shreg     <= data_reg << 1;
                                end
                            end else begin
                                if (fall) begin
                                    dout_q <= shreg[DATA_W-1];
                                    shreg  <= shreg << 1;
                                end
                                if (rise) begin
                                    bcnt <= bcnt + 1'b1;
                                    if (bcnt < BCW'(CMD_W)) cmd_sh <= cbits;
                                    if (bcnt == BCW'(7) && exit_hit) exit_pend <= 1'b1;
                                    if (frame_last) begin
                                        bcnt <= '0;  frame <= 1'b0;
                                        rdy_n <= !pend;  pend <= 1'b0;
                                    end
                                end
                            end
                        end
                        default: bcnt <= '0;
                    endcase
                end
                if (conv_valid) begin
                    data_reg <= conv_data;
                    rdy_n    <= 1'b0;
                    if (in_data_rd && !read_end) pend <= 1'b1;
                end
            end
        end
    end

    assign dout    = (st == S_RD || (st == S_CREAD && frame)) ? dout_q : rdy_n;
    assign dout_oe = !cs_n;
endmodule

// File: rtl/adc_cmd_port_chk.sv
module adc_cmd_port_chk #(
    parameter logic [7:0] MODE_DEF = 8'h00,
    parameter logic [7:0] FILT_DEF = 8'h04
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_act,
    input logic       srst,
    input logic       conv_valid,
    input logic       rdy_n,
    input logic [7:0] mode_cfg,
    input logic [7:0] filt_cfg,
    input logic [1:0] chan_sel,
    input logic       chan_restart
);
    a_r11_restart_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_sel != $past(chan_sel)) |-> chan_restart);

    a_r11_restart_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        chan_restart |=> !chan_restart);

    a_r10_hold_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> ($stable(mode_cfg) && $stable(filt_cfg) && $stable(chan_sel)));

    a_r9_soft_reset_defaults: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (mode_cfg == MODE_DEF && filt_cfg == FILT_DEF && chan_sel == 2'b00 && rdy_n));

    a_r5_ready_needs_result: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy_n) |-> $past(conv_valid));
endmodule

bind adc_cmd_port adc_cmd_port_chk #(.MODE_DEF(MODE_DEF), .FILT_DEF(FILT_DEF)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .srst(srst), .conv_valid(conv_valid),
    .rdy_n(rdy_n), .mode_cfg(mode_cfg), .filt_cfg(filt_cfg), .chan_sel(chan_sel),
    .chan_restart(chan_restart)
);

// File: tb/adc_cmd_port_test.sv
module adc_cmd_port_test;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n, cs_n, sclk, din, conv_valid;
    logic [23:0] conv_data;
    logic dout, dout_oe, chan_restart;
    logic [7:0] mode_cfg, filt_cfg;
    logic [1:0] chan_sel;

    adc_cmd_port uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
        .dout(dout), .dout_oe(dout_oe), .conv_data(conv_data), .conv_valid(conv_valid),
        .mode_cfg(mode_cfg), .filt_cfg(filt_cfg), .chan_sel(chan_sel),
        .chan_restart(chan_restart)
    );

    int n_chk = 0, n_bad = 0, pulses = 0, exp_pulses = 0;
    logic [1:0] ch = 2'b00;
    bit done = 0;

    always @(negedge clk) if (chan_restart) pulses++;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bit_x(input logic b, output logic o);
        @(negedge clk); sclk = 1'b0; din = b;
        repeat (8) @(negedge clk);
        o = dout; sclk = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic send(input logic [31:0] v, input int n, output logic [31:0] r);
        logic o;
        r = '0;
        for (int i = n - 1; i >= 0; i--) begin
            bit_x(v[i], o);
            r = {r[30:0], o};
        end
    endtask

    task automatic cmd(input logic [1:0] a, input logic rd, input logic cr);
        logic [31:0] r;
        send({24'h0, 2'b00, a, rd, cr, ch}, 8, r);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] v);
        logic [31:0] r;
        cmd(a, 1'b0, 1'b0);
        send({24'h0, v}, 8, r);
    endtask

    task automatic rd(input logic [1:0] a, input int n, output logic [31:0] r);
        cmd(a, 1'b1, 1'b0);
        send(32'h0, n, r);
    endtask

    task automatic setch(input logic [1:0] c);
        if (c != ch) exp_pulses++;
        ch = c;
    endtask

    task automatic cs_cycle();
        @(negedge clk); cs_n = 1'b1;
        repeat (6) @(negedge clk);
        cs_n = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic push(input logic [23:0] v);
        @(negedge clk); conv_data = v; conv_valid = 1'b1;
        @(negedge clk); conv_valid = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] r, r1, r2;
        logic [7:0] mv, fv;
        logic [23:0] dv;
        rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b1; din = 1'b0;
        conv_valid = 1'b0; conv_data = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R5 oe while deselected", dout_oe, 0);
        cs_n = 1'b0;
        repeat (6) @(negedge clk);
        chk("R5 oe while selected", dout_oe, 1);
        chk("R5 ready flag after reset", dout, 1);
        chk("R9 mode default", mode_cfg, 8'h00);
        chk("R9 filter default", filt_cfg, 8'h04);
        chk("R9 channel default", chan_sel, 0);

        // R1: leading ones are skipped before the start bit
        send(32'h1F, 5, r);
        wr(2'b01, 8'hA5);
        rd(2'b01, 8, r);
        chk("R1 command after leading ones", r[7:0], 8'hA5);

        // R3 R4 sweep of mode and filter
        for (int i = 0; i < 16; i++) begin
            mv = 8'((i * 37 + 11) & 8'hFF);
            fv = ~mv ^ 8'(i << 4);
            wr(2'b01, mv);
            wr(2'b10, fv);
            chk("R3 mode port", mode_cfg, mv);
            chk("R3 filter port", filt_cfg, fv);
            rd(2'b01, 8, r);
            chk("R4 mode readback", r[7:0], mv);
            rd(2'b10, 8, r);
            chk("R4 filter readback", r[7:0], fv);
        end

        // R3 writes to 00 and 11 end at the command byte
        cmd(2'b11, 1'b0, 1'b0);
        wr(2'b01, 8'h77);
        chk("R3 write to result ends at command", mode_cfg, 8'h77);
        cmd(2'b00, 1'b0, 1'b0);
        wr(2'b01, 8'h78);
        chk("R3 write to 00 ends at command", mode_cfg, 8'h78);

        // R2 byte with bit 6 set is discarded
        send(32'h53, 8, r);
        chk("R2 bad byte keeps channel", chan_sel, ch);
        chk("R2 bad byte no pulse", pulses, exp_pulses);
        rd(2'b01, 8, r);
        chk("R2 bad byte keeps mode", r[7:0], 8'h78);

        // R11 channel changes and status
        setch(2'b10);
        rd(2'b00, 8, r);
        chk("R11 channel port", chan_sel, 2'b10);
        chk("R4 status idle", r[7:0], {1'b1, 5'b0, 2'b10});
        chk("R11 one pulse on change", pulses, exp_pulses);
        rd(2'b00, 8, r);
        chk("R11 no pulse on same channel", pulses, exp_pulses);
        setch(2'b11);
        rd(2'b01, 8, r);
        setch(2'b00);
        rd(2'b01, 8, r);
        chk("R11 pulses after two changes", pulses, exp_pulses);

        // R4 R5 R6 result reads
        for (int i = 0; i < 10; i++) begin
            case (i)
                0: dv = 24'h800000;
                1: dv = 24'h000000;
                2: dv = 24'hFFFFFF;
                default: dv = 24'((i * 32'h2A5F1D) ^ 32'h13579B);
            endcase
            push(dv);
            chk("R5 ready low after result", dout, 0);
            rd(2'b11, 24, r);
            chk("R4 R6 result readback", r[23:0], dv);
            chk("R5 ready high after read", dout, 1);
        end

        push(24'h123456);
        rd(2'b00, 8, r);
        chk("R4 status with result pending", r[7:0], {1'b0, 5'b0, ch});
        rd(2'b11, 24, r);

        // R5 result arriving during a result read
        cmd(2'b11, 1'b1, 1'b0);
        send(32'h0, 12, r1);
        push(24'hABCDEF);
        send(32'h0, 12, r2);
        chk("R5 first result intact", {r1[11:0], r2[11:0]}, 24'h123456);
        chk("R5 ready stays low", dout, 0);
        rd(2'b11, 24, r);
        chk("R5 newer result", r[23:0], 24'hABCDEF);
        chk("R5 ready high after second read", dout, 1);

        // R7 streaming mode
        cmd(2'b11, 1'b1, 1'b1);
        send(32'h0, 8, r);
        chk("R7 no shift while not ready", r[7:0], 8'hFF);
        push(24'h5A5A01);
        send(32'h0, 24, r);
        chk("R7 first streamed result", r[23:0], 24'h5A5A01);
        push(24'h0F1E2D);
        send(32'h0, 24, r);
        chk("R7 second streamed result", r[23:0], 24'h0F1E2D);
        chk("R7 ready high after frame", dout, 1);

        // R8 exit from streaming
        push(24'hC3C3C3);
        send({8'h0, 6'b001110, ch, 16'h0}, 24, r);
        chk("R8 frame carrying exit", r[23:0], 24'hC3C3C3);
        push(24'h246801);
        rd(2'b01, 8, r);
        chk("R8 command accepted after exit", r[7:0], 8'h78);
        rd(2'b11, 24, r);
        chk("R8 result after exit", r[23:0], 24'h246801);

        // R9 31 ones do not reset, 32 do (also in streaming)
        wr(2'b01, 8'h5A);
        send(32'h7FFFFFFF, 31, r);
        rd(2'b01, 8, r);
        chk("R9 31 ones keep mode", r[7:0], 8'h5A);
        setch(2'b01);
        wr(2'b10, 8'h99);
        cmd(2'b11, 1'b1, 1'b1);
        send(32'hFFFFFFFF, 32, r);
        setch(2'b00);
        chk("R9 reset mode", mode_cfg, 8'h00);
        chk("R9 reset filter", filt_cfg, 8'h04);
        chk("R9 reset channel", chan_sel, 0);
        chk("R9 reset pulse count", pulses, exp_pulses);
        rd(2'b10, 8, r);
        chk("R9 command wait after reset", r[7:0], 8'h04);

        // R10 ones run survives deselect; partial byte abandoned
        wr(2'b01, 8'h66);
        send(32'hFFFFF, 20, r);
        cs_cycle();
        send(32'hFFF, 12, r);
        chk("R10 run kept across deselect", mode_cfg, 8'h00);
        send(32'h1, 4, r);
        cs_cycle();
        wr(2'b01, 8'h33);
        rd(2'b01, 8, r);
        chk("R10 partial byte abandoned", r[7:0], 8'h33);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule